// File: doc/BRIEF.md
# Dual-Mode Bit Error Rate Alarm Monitor

This block watches the per-frame parity error counts produced by two parity monitors and decides whether the line has degraded or failed. It has two independent alarm engines, one for signal degrade and one for signal fail. Each engine has its own window length in frames, its own set threshold, clear threshold and decrement value. A single mode bit makes both engines run as a leaky bucket or as a per-window rate detector.

Every entry into or exit from an alarm sets a sticky status bit. The status bits, gated by mask bits, drive one interrupt line. Status is cleared either by a read strobe or by a write strobe carrying a bit mask, depending on a global setting. While any framing alarm input is active, error counting stops and the frame window counters restart from zero. Framing, parity generation and the register bus decode sit outside this block.

Top module: `ber_alarm_monitor`

## Requirements
- R1: When `srcSel` is 0 the error count of each frame is taken from `errCntA`; when it is 1 it is taken from `errCntB`. The unselected input has no effect.
- R2: Each engine counts frame strobes. A window ends on the strobe that completes `window` frames. A window value of 0 behaves like 1. The errors of the frame that ends a window are included in that window's total.
- R3: In leaky-bucket mode (`rateMode`=0), an inactive alarm asserts at a window end whose total is greater than or equal to the set threshold. The alarm output changes on the clock edge that samples the ending frame strobe.
- R4: In leaky-bucket mode an active alarm releases only at a window end whose total is below the clear threshold. After the comparison the accumulator is reduced by the decrement value and floors at zero rather than wrapping.
- R5: In rate mode (`rateMode`=1) the accumulator is zeroed at every window end, and the decrement and clear threshold have no effect. The alarm follows each window's total: on when it is at or above the set threshold, off when it is below.
- R6: While `losIn`, `lofIn` or `sefIn` is high, frame strobes add no errors and end no window, and the window frame counters return to zero.
- R7: Status bit 0 (degrade) and bit 1 (fail) are set on the same edge as the assertion or release of their alarm. They stay set until cleared.
- R8: `irq` is high exactly when some status bit is set and its `intMask` bit is 0.
- R9: With `clrOnRead`=0, a `statWrite` pulse clears every status bit whose `statWdata` bit is 1, and `statRead` has no effect.
- R10: With `clrOnRead`=1, a `statRead` pulse clears all status bits. A set event in the same cycle wins over a clear.
- R11: After reset both alarms, all status bits and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStrobe | input | 1 | One-cycle pulse per frame, carrying that frame's error counts |
| errCntA | input | 4 | Parity errors in the frame from the first monitor (0 to 8) |
| errCntB | input | 4 | Parity errors in the frame from the second monitor (0 to 8) |
| losIn | input | 1 | Loss of signal alarm |
| lofIn | input | 1 | Loss of frame alarm |
| sefIn | input | 1 | Severely errored frame alarm |
| srcSel | input | 1 | Error source select: 0 first monitor, 1 second |
| rateMode | input | 1 | 0 leaky bucket, 1 rate detection |
| clrOnRead | input | 1 | Status clear policy: 1 on read, 0 on write |
| sdWindow | input | 20 | Degrade window length in frames |
| sdSetThr | input | 19 | Degrade set threshold |
| sdClrThr | input | 19 | Degrade clear threshold |
| sdDec | input | 15 | Degrade decrement per window |
| sfWindow | input | 20 | Fail window length in frames |
| sfSetThr | input | 19 | Fail set threshold |
| sfClrThr | input | 19 | Fail clear threshold |
| sfDec | input | 15 | Fail decrement per window |
| intMask | input | 2 | Interrupt mask, bit 0 degrade, bit 1 fail; 1 masks |
| statRead | input | 1 | Status read strobe |
| statWrite | input | 1 | Status write strobe |
| statWdata | input | 2 | Status write data, 1 clears that bit |
| sdAlarm | output | 1 | Signal degrade alarm state |
| sfAlarm | output | 1 | Signal fail alarm state |
| status | output | 2 | Sticky status, bit 0 degrade, bit 1 fail |
| irq | output | 1 | Masked interrupt |

## Verification
The main leaky-bucket test feeds one sequence of error counts to both engines at once. Because the two engines use different window lengths and thresholds, the same traffic tests a short window with a floor-at-zero decrement and a long window with a held alarm. The sequence includes bursts that cross the set threshold, quiet frames that keep the total above the clear threshold, and quiet frames that finally drop below it, so a missed hysteresis or a wrapping decrement shows up as a wrong alarm. In rate mode a separate pattern passes through the threshold and back, with the clear threshold and decrement set to values that would keep a leaky bucket latched. The framing alarm test orders frames so that a counter that does not restart and errors that are not ignored each produce a different alarm value.

// File: rtl/ber_pkg.sv
package ber_pkg;
  localparam int ACC_W   = 19;
  localparam int WIN_W   = 20;
  localparam int DEC_W   = 15;
  localparam int ERR_W   = 4;
  localparam int NUM_ENG = 2;

  // strobes from window control to the accumulator datapath
  typedef struct packed {
    logic countErr;  // a frame is being monitored this cycle
    logic winEnd;    // this frame closes the window
  } winStrobe_t;
endpackage

// File: rtl/ber_window_ctrl.sv
module ber_window_ctrl
  import ber_pkg::*;
#(
  parameter int WW = WIN_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStrobe,
  input  logic          framingAlarm,
  input  logic [WW-1:0] winLen,
  output winStrobe_t    strb
);
  logic [WW-1:0] frameCnt;
  logic [WW:0]   nextCount;
  logic          lastFrame;

  assign nextCount = {1'b0, frameCnt} + {{WW{1'b0}}, 1'b1};
  // a zero length compares as complete on every frame, acting like one
  assign lastFrame = nextCount >= {1'b0, winLen};

  always_comb begin
    strb.countErr = frameStrobe & ~framingAlarm;
    strb.winEnd   = frameStrobe & ~framingAlarm & lastFrame;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      frameCnt <= '0;
    else if (framingAlarm)
      frameCnt <= '0;
    else if (frameStrobe)
      frameCnt <= lastFrame ? '0 : nextCount[WW-1:0];
  end

  a_r6_counter_restarts: assert property (@(posedge clk) disable iff (!rstN)
    framingAlarm |=> frameCnt == '0);

  a_r2_end_resets_count: assert property (@(posedge clk) disable iff (!rstN)
    strb.winEnd |=> frameCnt == '0);
endmodule

// File: rtl/ber_accum_path.sv
module ber_accum_path
  import ber_pkg::*;
#(
  parameter int AW = ACC_W,
  parameter int DW = DEC_W,
  parameter int EW = ERR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  winStrobe_t    strb,
  input  logic [EW-1:0] errIn,
  input  logic [AW-1:0] setThr,
  input  logic [AW-1:0] clrThr,
  input  logic [DW-1:0] decVal,
  input  logic          rateMode,
  output logic          alarm,
  output logic          alarmEvt
);
  localparam logic [AW-1:0] ACC_MAX = '1;

  logic [AW-1:0] acc;
  logic [AW:0]   sumWide;
  logic [AW-1:0] total;
  logic [AW-1:0] decWide;
  logic [AW-1:0] accAfter;
  logic          alarmNext;

  assign sumWide = {1'b0, acc} + {{(AW+1-EW){1'b0}}, errIn};
  assign total   = sumWide[AW] ? ACC_MAX : sumWide[AW-1:0];
  assign decWide = {{(AW-DW){1'b0}}, decVal};

  always_comb begin
    if (rateMode) begin
      alarmNext = total >= setThr;
      accAfter  = '0;
    end else begin
      alarmNext = alarm ? (total >= clrThr) : (total >= setThr);
      accAfter  = (total >= decWide) ? (total - decWide) : '0;
    end
  end

  assign alarmEvt = strb.winEnd & (alarmNext != alarm);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc   <= '0;
      alarm <= 1'b0;
    end else if (strb.countErr) begin
      acc <= strb.winEnd ? accAfter : total;
      if (strb.winEnd)
        alarm <= alarmNext;
    end
  end

  a_r3_alarm_moves_at_window_end: assert property (@(posedge clk) disable iff (!rstN)
    !strb.winEnd |=> $stable(alarm));

  a_r5_rate_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    (strb.winEnd && rateMode) |=> acc == '0);

  a_r4_no_wrap_between_ends: assert property (@(posedge clk) disable iff (!rstN)
    !strb.winEnd |=> acc >= $past(acc));

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.countErr |=> $stable(acc));
endmodule

// File: rtl/ber_status_regs.sv
module ber_status_regs #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] setEvt,
  input  logic         clrOnRead,
  input  logic         statRead,
  input  logic         statWrite,
  input  logic [N-1:0] statWdata,
  input  logic [N-1:0] intMask,
  output logic [N-1:0] status,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic clrReq;
    assign clrReq = clrOnRead ? statRead : (statWrite & statWdata[i]);

    always_ff @(posedge clk) begin
      if (!rstN)
        status[i] <= 1'b0;
      else if (setEvt[i])
        status[i] <= 1'b1;
      else if (clrReq)
        status[i] <= 1'b0;
    end

    a_r7_event_sets: assert property (@(posedge clk) disable iff (!rstN)
      setEvt[i] |=> status[i]);

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rstN)
      (clrOnRead && statRead && !setEvt[i]) |=> !status[i]);

    a_r9_read_ignored: assert property (@(posedge clk) disable iff (!rstN)
      (!clrOnRead && !statWrite && status[i]) |=> status[i]);
  end

  assign irq = |(status & ~intMask);

  always_comb begin
    a_r8_irq_gate: assert (irq == (status != '0 && (status & ~intMask) != '0));
  end
endmodule

// File: rtl/ber_alarm_monitor.sv
module ber_alarm_monitor
  import ber_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStrobe,
  input  logic [ERR_W-1:0] errCntA,
  input  logic [ERR_W-1:0] errCntB,
  input  logic             losIn,
  input  logic             lofIn,
  input  logic             sefIn,
  input  logic             srcSel,
  input  logic             rateMode,
  input  logic             clrOnRead,
  input  logic [WIN_W-1:0] sdWindow,
  input  logic [ACC_W-1:0] sdSetThr,
  input  logic [ACC_W-1:0] sdClrThr,
  input  logic [DEC_W-1:0] sdDec,
  input  logic [WIN_W-1:0] sfWindow,
  input  logic [ACC_W-1:0] sfSetThr,
  input  logic [ACC_W-1:0] sfClrThr,
  input  logic [DEC_W-1:0] sfDec,
  input  logic [NUM_ENG-1:0] intMask,
  input  logic             statRead,
  input  logic             statWrite,
  input  logic [NUM_ENG-1:0] statWdata,
  output logic             sdAlarm,
  output logic             sfAlarm,
  output logic [NUM_ENG-1:0] status,
  output logic             irq
);
  logic             framingAlarm;
  logic [ERR_W-1:0] errSel;
  logic [NUM_ENG-1:0] alarmVec;
  logic [NUM_ENG-1:0] evtVec;

  assign framingAlarm = losIn | lofIn | sefIn;
  assign errSel       = srcSel ? errCntB : errCntA;

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
    winStrobe_t strb;

    ber_window_ctrl #(.WW(WIN_W)) u_ctrl (
      .clk          (clk),
      .rstN         (rstN),
      .frameStrobe  (frameStrobe),
      .framingAlarm (framingAlarm),
      .winLen       (g == 0 ? sdWindow : sfWindow),
      .strb         (strb)
    );

    ber_accum_path #(.AW(ACC_W), .DW(DEC_W), .EW(ERR_W)) u_path (
      .clk      (clk),
      .rstN     (rstN),
      .strb     (strb),
      .errIn    (errSel),
      .setThr   (g == 0 ? sdSetThr : sfSetThr),
      .clrThr   (g == 0 ? sdClrThr : sfClrThr),
      .decVal   (g == 0 ? sdDec : sfDec),
      .rateMode (rateMode),
      .alarm    (alarmVec[g]),
      .alarmEvt (evtVec[g])
    );
  end

  ber_status_regs #(.N(NUM_ENG)) u_status (
    .clk       (clk),
    .rstN      (rstN),
    .setEvt    (evtVec),
    .clrOnRead (clrOnRead),
    .statRead  (statRead),
    .statWrite (statWrite),
    .statWdata (statWdata),
    .intMask   (intMask),
    .status    (status),
    .irq       (irq)
  );

  assign sdAlarm = alarmVec[0];
  assign sfAlarm = alarmVec[1];

  a_r7_status_tracks_change: assert property (@(posedge clk) disable iff (!rstN)
    (sdAlarm != $past(sdAlarm)) |-> status[0]);
endmodule

// File: tb/ber_alarm_monitor_tb.sv
module ber_alarm_monitor_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStrobe = 1'b0;
  logic [3:0]  errCntA = '0, errCntB = '0;
  logic        losIn = 1'b0, lofIn = 1'b0, sefIn = 1'b0;
  logic        srcSel = 1'b0, rateMode = 1'b0, clrOnRead = 1'b0;
  logic [19:0] sdWindow = 20'd1, sfWindow = 20'd1;
  logic [18:0] sdSetThr = '1, sdClrThr = '0, sfSetThr = '1, sfClrThr = '0;
  logic [14:0] sdDec = '0, sfDec = '0;
  logic [1:0]  intMask = 2'b00;
  logic        statRead = 1'b0, statWrite = 1'b0;
  logic [1:0]  statWdata = '0;
  logic        sdAlarm, sfAlarm, irq;
  logic [1:0]  status;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ber_alarm_monitor u_dut (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe),
    .errCntA(errCntA), .errCntB(errCntB),
    .losIn(losIn), .lofIn(lofIn), .sefIn(sefIn),
    .srcSel(srcSel), .rateMode(rateMode), .clrOnRead(clrOnRead),
    .sdWindow(sdWindow), .sdSetThr(sdSetThr), .sdClrThr(sdClrThr), .sdDec(sdDec),
    .sfWindow(sfWindow), .sfSetThr(sfSetThr), .sfClrThr(sfClrThr), .sfDec(sfDec),
    .intMask(intMask), .statRead(statRead), .statWrite(statWrite),
    .statWdata(statWdata), .sdAlarm(sdAlarm), .sfAlarm(sfAlarm),
    .status(status), .irq(irq)
  );

  // each row: {errCntA[3:0], expected sdAlarm, expected sfAlarm}
  // degrade: window 4, set 6, clear 3, dec 2; fail: window 2, set 9, clear 4, dec 5
  localparam logic [5:0] VEC [12] = '{
    {4'd2, 1'b0, 1'b0}, {4'd2, 1'b0, 1'b0}, {4'd1, 1'b0, 1'b0}, {4'd3, 1'b1, 1'b0},
    {4'd8, 1'b1, 1'b0}, {4'd8, 1'b1, 1'b1}, {4'd0, 1'b1, 1'b1}, {4'd0, 1'b1, 1'b1},
    {4'd0, 1'b1, 1'b1}, {4'd0, 1'b1, 1'b1}, {4'd0, 1'b1, 1'b1}, {4'd0, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // one frame, sampled at the negedge after the edge that takes it
  task automatic frame(input logic [3:0] a, input logic [3:0] b, input logic fa);
    @(negedge clk);
    errCntA = a; errCntB = b; losIn = fa; frameStrobe = 1'b1;
    @(negedge clk);
    frameStrobe = 1'b0; errCntA = '0; errCntB = '0; losIn = 1'b0;
  endtask

  task automatic pulseRead();
    @(negedge clk); statRead = 1'b1;
    @(negedge clk); statRead = 1'b0;
  endtask

  task automatic pulseWrite(input logic [1:0] d);
    @(negedge clk); statWrite = 1'b1; statWdata = d;
    @(negedge clk); statWrite = 1'b0; statWdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R11: reset state, mask open so irq is meaningful
    doReset();
    chk("R11 sdAlarm", sdAlarm, 0);
    chk("R11 sfAlarm", sfAlarm, 0);
    chk("R11 status", status, 0);
    chk("R11 irq", irq, 0);

    // R3 R4 R2 leaky bucket table, first monitor selected (R1), second is noise
    sdWindow = 20'd4; sdSetThr = 19'd6; sdClrThr = 19'd3; sdDec = 15'd2;
    sfWindow = 20'd2; sfSetThr = 19'd9; sfClrThr = 19'd4; sfDec = 15'd5;
    intMask = 2'b11;
    doReset();
    for (int i = 0; i < 12; i++) begin
      frame(VEC[i][5:2], 4'd8, 1'b0);
      chk($sformatf("R3/R4 sdAlarm frame %0d", i), sdAlarm, VEC[i][1]);
      chk($sformatf("R3/R4 sfAlarm frame %0d", i), sfAlarm, VEC[i][0]);
    end

    // R7 both bits sticky; R8 masking
    chk("R7 status after table", status, 2'b11);
    chk("R8 irq all masked", irq, 0);
    @(negedge clk); intMask = 2'b10; #1;
    chk("R8 irq degrade unmasked", irq, 1);

    // R9 clear on write, reads ignored
    clrOnRead = 1'b0;
    pulseRead();
    chk("R9 read ignored", status, 2'b11);
    pulseWrite(2'b01);
    chk("R9 write clears bit0", status, 2'b10);
    chk("R8 irq with fail masked", irq, 0);

    // R10 clear on read
    clrOnRead = 1'b1;
    pulseRead();
    chk("R10 read clears all", status, 2'b00);

    // R5 rate mode: clear 0 and dec 0 would latch a leaky bucket
    rateMode = 1'b1; clrOnRead = 1'b0; intMask = 2'b00;
    sdWindow = 20'd3; sdSetThr = 19'd4; sdClrThr = 19'd0; sdDec = 15'd0;
    sfWindow = 20'd1; sfSetThr = 19'd100;
    doReset();
    frame(4'd2, 4'd0, 1'b0);
    frame(4'd2, 4'd0, 1'b0);
    frame(4'd0, 4'd0, 1'b0);
    chk("R5 rate assert", sdAlarm, 1);
    chk("R7 status on assert", status, 2'b01);
    chk("R8 irq unmasked", irq, 1);
    pulseWrite(2'b01);
    frame(4'd1, 4'd0, 1'b0);
    chk("R5 rate held mid window", sdAlarm, 1);
    frame(4'd1, 4'd0, 1'b0);
    frame(4'd1, 4'd0, 1'b0);
    chk("R5 rate release", sdAlarm, 0);
    chk("R7 status on release", status, 2'b01);

    // R1 second monitor, R2 window 0 acts as 1
    rateMode = 1'b0; srcSel = 1'b1;
    sdWindow = 20'd0; sdSetThr = 19'd4; sdClrThr = 19'd1; sdDec = 15'd0;
    doReset();
    frame(4'd8, 4'd0, 1'b0);
    chk("R1 first monitor ignored", sdAlarm, 0);
    frame(4'd0, 4'd5, 1'b0);
    chk("R1 R2 second monitor one frame window", sdAlarm, 1);

    // R6 window counter restarts during framing alarm
    srcSel = 1'b0; sdWindow = 20'd2;
    doReset();
    frame(4'd3, 4'd0, 1'b0);
    frame(4'd8, 4'd0, 1'b1);
    frame(4'd0, 4'd0, 1'b0);
    chk("R6 window restarted", sdAlarm, 0);
    frame(4'd1, 4'd0, 1'b0);
    chk("R6 window end after restart", sdAlarm, 1);

    // R6 errors ignored during framing alarm
    doReset();
    frame(4'd8, 4'd0, 1'b1);
    frame(4'd0, 4'd0, 1'b0);
    frame(4'd0, 4'd0, 1'b0);
    chk("R6 errors ignored", sdAlarm, 0);
    chk("R6 no status", status, 2'b00);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule